// File: doc/BRIEF.md
# Zero-Cross Gated Volume Controller

This block decides when a new volume or mute setting reaches a stereo TV audio output. A register file supplies a 3-bit coarse attenuation code (8 dB per step), a 3-bit fine attenuation code (1 dB per step), a mute request and a gating enable. A one-cycle load strobe marks each newly written instruction. When gating is off, the setting is applied on the load. When gating is on, the setting is held as pending and is applied only when the audio signal next crosses zero. This avoids audible clicks when the level changes.

The block watches a signed sample stream for both stereo channels, qualified by a valid strobe. It reports the applied codes, the summed attenuation in dB, and the applied mute state. An effective attenuation figure takes the mute into account. A sticky status flag shows whether a crossing has occurred since the last instruction. A hardware mute input forces the effective mute at any time and does not disturb the stored settings. One mute result serves the left, right and mono outputs.

Top module: `zcv_volume_ctrl`

## Requirements
- R1: After reset, the applied coarse and fine codes are 0, attenuation is 0 dB, applied mute and effective mute are 0, nothing is pending, and the status flag is 0.
- R2: `atten_db` equals 8 times the applied coarse code plus the applied fine code, giving a range of 0 to 63. `eff_atten_db` equals `atten_db` when the effective mute is 0, and 80 when it is 1.
- R3: A load with `zc_gate`=0 applies the coarse code, fine code and mute flag at that clock edge. It also discards any pending setting, so a later crossing changes nothing.
- R4: A load with `zc_gate`=1 leaves the applied values unchanged and stores the setting as pending. The pending setting is applied at the first later clock edge where a crossing is detected.
- R5: A crossing is detected on a valid sample when either channel's sign bit differs from that channel's sign bit in the previous valid sample, or when either channel's sample is exactly zero. The first valid sample after reset counts as a crossing only if it is zero.
- R6: The status flag is cleared by every load. It is set by the first crossing detected after that load, and it stays set until the next load.
- R7: A new gated load while a setting is pending replaces the pending values. Only the latest setting is applied at the crossing.
- R8: While `hw_mute` is 1, `out_mute` is 1 and `eff_atten_db` is 80, whatever the register settings. The applied codes and the applied mute flag are not affected.
- R9: When a load coincides with a crossing, the load takes priority. A gated setting stays pending and the status flag reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | One-cycle strobe marking a new instruction |
| coarse_in | input | 3 | Requested coarse code, 8 dB per step |
| fine_in | input | 3 | Requested fine code, 1 dB per step |
| mute_in | input | 1 | Requested mute |
| zc_gate | input | 1 | 1: apply at the next zero crossing; 0: apply at once |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | 16 | Signed left-channel sample |
| smp_right | input | 16 | Signed right-channel sample |
| hw_mute | input | 1 | Hardware mute override, active high |
| applied_coarse | output | 3 | Coarse code in effect |
| applied_fine | output | 3 | Fine code in effect |
| atten_db | output | 6 | Summed attenuation in dB |
| applied_mute | output | 1 | Register mute in effect |
| out_mute | output | 1 | Effective mute for left, right and mono |
| eff_atten_db | output | 7 | Attenuation including mute (80 when muted) |
| zc_status | output | 1 | Sticky flag: crossing seen since last load |

## Verification
The assertions check four behaviours on every cycle:
- An ungated load reaches the applied codes one edge later.
- The applied settings stay frozen while a setting waits without a crossing.
- The pending state clears when a crossing occurs.
- The status flag clears on a load, stays set until the next load, and hardware mute always forces the effective mute.

Other behaviours only the bench's scenarios can show. These include the crossing definition itself: the first sample after reset, the zero-valued sample, and the sign change on either channel. The bench also covers replacement of a pending value by a newer load, and the priority of a load over a coincident crossing.

// File: rtl/zcv_pkg.sv
package zcv_pkg;

  // Summed attenuation in dB from the two step codes.
  function automatic int atten_of(input int coarse, input int fine,
                                  input int coarse_step, input int fine_step);
    return coarse * coarse_step + fine * fine_step;
  endfunction

  // Attenuation presented once mute is considered.
  function automatic int effective_of(input int sum_db, input logic muted,
                                      input int mute_db);
    return muted ? mute_db : sum_db;
  endfunction

  // Larger of two values, used to size ports.
  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/zcv_zero_detect.sv
module zcv_zero_detect #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                zc_event
);
  localparam int SIGN = SAMPLE_W - 1;

  logic prev_sign_l, prev_sign_r, have_prev;
  logic sign_flip, is_zero;

  assign sign_flip = have_prev &&
                     ((smp_left[SIGN] != prev_sign_l) || (smp_right[SIGN] != prev_sign_r));
  assign is_zero   = (smp_left == '0) || (smp_right == '0);
  assign zc_event  = smp_valid && (sign_flip || is_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sign_l <= 1'b0;
      prev_sign_r <= 1'b0;
      have_prev   <= 1'b0;
    end else if (smp_valid) begin
      prev_sign_l <= smp_left[SIGN];
      prev_sign_r <= smp_right[SIGN];
      have_prev   <= 1'b1;
    end
  end
endmodule

// File: rtl/zcv_setting_reg.sv
module zcv_setting_reg #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              zc_gate,
  input  logic [CODE_W-1:0] coarse_in,
  input  logic [CODE_W-1:0] fine_in,
  input  logic              mute_in,
  input  logic              zc_event,
  output logic [CODE_W-1:0] applied_coarse,
  output logic [CODE_W-1:0] applied_fine,
  output logic              applied_mute,
  output logic              pend_valid
);
  logic [CODE_W-1:0] pend_coarse, pend_fine;
  logic              pend_mute;
  logic              take_now, take_pending;

  assign take_now     = load && !zc_gate;
  assign take_pending = !load && pend_valid && zc_event;

  // Shadow (pending) registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_coarse <= '0;
      pend_fine   <= '0;
      pend_mute   <= 1'b0;
      pend_valid  <= 1'b0;
    end else if (load) begin
      pend_coarse <= coarse_in;
      pend_fine   <= fine_in;
      pend_mute   <= mute_in;
      pend_valid  <= zc_gate;
    end else if (take_pending) begin
      pend_valid  <= 1'b0;
    end
  end

  // Applied registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_coarse <= '0;
      applied_fine   <= '0;
      applied_mute   <= 1'b0;
    end else if (take_now) begin
      applied_coarse <= coarse_in;
      applied_fine   <= fine_in;
      applied_mute   <= mute_in;
    end else if (take_pending) begin
      applied_coarse <= pend_coarse;
      applied_fine   <= pend_fine;
      applied_mute   <= pend_mute;
    end
  end
endmodule

// File: rtl/zcv_status.sv
module zcv_status (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic zc_event,
  output logic zc_status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        zc_status <= 1'b0;
    else if (load)     zc_status <= 1'b0;
    else if (zc_event) zc_status <= 1'b1;
  end
endmodule

// File: rtl/zcv_volume_ctrl.sv
module zcv_volume_ctrl #(
  parameter int CODE_W      = 3,
  parameter int SAMPLE_W    = 16,
  parameter int COARSE_STEP = 8,
  parameter int FINE_STEP   = 1,
  parameter int MUTE_DB     = 80,
  localparam int CODE_MAX   = (1 << CODE_W) - 1,
  localparam int SUM_MAX    = CODE_MAX * COARSE_STEP + CODE_MAX * FINE_STEP,
  localparam int ATTN_W     = $clog2(SUM_MAX + 1),
  localparam int EFF_W      = $clog2(zcv_pkg::max_of(SUM_MAX, MUTE_DB) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CODE_W-1:0]   coarse_in,
  input  logic [CODE_W-1:0]   fine_in,
  input  logic                mute_in,
  input  logic                zc_gate,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                hw_mute,
  output logic [CODE_W-1:0]   applied_coarse,
  output logic [CODE_W-1:0]   applied_fine,
  output logic [ATTN_W-1:0]   atten_db,
  output logic                applied_mute,
  output logic                out_mute,
  output logic [EFF_W-1:0]    eff_atten_db,
  output logic                zc_status
);
  logic zc_event;
  logic pend_valid;

  zcv_zero_detect #(.SAMPLE_W(SAMPLE_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .zc_event(zc_event)
  );

  zcv_setting_reg #(.CODE_W(CODE_W)) u_setting (
    .clk(clk), .rst_n(rst_n), .load(load), .zc_gate(zc_gate),
    .coarse_in(coarse_in), .fine_in(fine_in), .mute_in(mute_in),
    .zc_event(zc_event), .applied_coarse(applied_coarse),
    .applied_fine(applied_fine), .applied_mute(applied_mute),
    .pend_valid(pend_valid)
  );

  zcv_status u_status (
    .clk(clk), .rst_n(rst_n), .load(load), .zc_event(zc_event),
    .zc_status(zc_status)
  );

  assign out_mute = applied_mute || hw_mute;

  always_comb begin
    int sum_db;
    sum_db       = zcv_pkg::atten_of(int'(applied_coarse), int'(applied_fine),
                                     COARSE_STEP, FINE_STEP);
    atten_db     = ATTN_W'(sum_db);
    eff_atten_db = EFF_W'(zcv_pkg::effective_of(sum_db, out_mute, MUTE_DB));
  end
endmodule

// File: rtl/zcv_checker.sv
module zcv_checker #(
  parameter int CODE_W  = 3,
  parameter int EFF_W   = 7,
  parameter int MUTE_DB = 80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              zc_gate,
  input logic [CODE_W-1:0] coarse_in,
  input logic [CODE_W-1:0] fine_in,
  input logic              hw_mute,
  input logic [CODE_W-1:0] applied_coarse,
  input logic [CODE_W-1:0] applied_fine,
  input logic              applied_mute,
  input logic              out_mute,
  input logic [EFF_W-1:0]  eff_atten_db,
  input logic              zc_status,
  input logic              zc_event,
  input logic              pend_valid
);
  a_r3_immediate_apply: assert property (@(posedge clk) disable iff (!rst_n)
    load && !zc_gate |=> applied_coarse == $past(coarse_in) && applied_fine == $past(fine_in));

  a_r4_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && !zc_event && !load |=>
      $stable(applied_coarse) && $stable(applied_fine) && $stable(applied_mute));

  a_r4_pending_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && zc_event && !load |=> !pend_valid);

  a_r6_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !zc_status);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    zc_status && !load |=> zc_status);

  a_r8_hw_override: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mute |-> out_mute && eff_atten_db == EFF_W'(MUTE_DB));
endmodule

bind zcv_volume_ctrl zcv_checker #(.CODE_W(CODE_W), .EFF_W(EFF_W), .MUTE_DB(MUTE_DB)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .zc_gate(zc_gate),
  .coarse_in(coarse_in), .fine_in(fine_in), .hw_mute(hw_mute),
  .applied_coarse(applied_coarse), .applied_fine(applied_fine),
  .applied_mute(applied_mute), .out_mute(out_mute), .eff_atten_db(eff_atten_db),
  .zc_status(zc_status), .zc_event(zc_event), .pend_valid(pend_valid)
);

// File: tb/zcv_volume_ctrl_tb.sv
module zcv_volume_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic load = 0, mute_in = 0, zc_gate = 0, smp_valid = 0, hw_mute = 0;
  logic [2:0] coarse_in = 0, fine_in = 0;
  logic [15:0] smp_left = 0, smp_right = 0;
  logic [2:0] applied_coarse, applied_fine;
  logic [5:0] atten_db;
  logic applied_mute, out_mute, zc_status;
  logic [6:0] eff_atten_db;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  zcv_volume_ctrl u_dut (.*);

  // {coarse, fine, mute, expected effective attenuation}
  localparam logic [13:0] VEC [6] = '{
    {3'd0, 3'd0, 1'b0, 7'd0},  {3'd7, 3'd7, 1'b0, 7'd63},
    {3'd3, 3'd5, 1'b0, 7'd29}, {3'd1, 3'd0, 1'b1, 7'd80},
    {3'd0, 3'd1, 1'b0, 7'd1},  {3'd7, 3'd0, 1'b0, 7'd56}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic g, input int c, input int f,
                      input logic m, input logic v, input int l, input int r);
    load = ld; zc_gate = g; coarse_in = 3'(c); fine_in = 3'(f); mute_in = m;
    smp_valid = v; smp_left = 16'(l); smp_right = 16'(r);
    @(posedge clk); #2;
    load = 0; smp_valid = 0;
  endtask

  task automatic expect_set(input string req, input int c, input int f, input int m,
                            input int st);
    chk({req, " coarse"}, applied_coarse, c);
    chk({req, " fine"}, applied_fine, f);
    chk({req, " mute"}, applied_mute, m);
    chk({req, " status"}, zc_status, st);
    chk({req, " atten"}, atten_db, c * 8 + f);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #22 rst_n = 1; #5;
    // R1 reset state
    expect_set("R1", 0, 0, 0, 0);
    chk("R1 out_mute", out_mute, 0);
    chk("R1 eff", eff_atten_db, 0);

    // R2/R3 table of immediate loads
    for (int i = 0; i < 6; i++) begin
      step(1, 0, VEC[i][13:11], VEC[i][10:8], VEC[i][7], 0, 0, 0);
      chk("R3 coarse", applied_coarse, VEC[i][13:11]);
      chk("R2 atten", atten_db, VEC[i][13:11] * 8 + VEC[i][10:8]);
      chk("R2 eff", eff_atten_db, VEC[i][6:0]);
    end
    // applied is now 7,0,0

    // R4 gated load stays pending
    step(1, 1, 2, 3, 0, 0, 0, 0);
    expect_set("R4 pending", 7, 0, 0, 0);
    // R5 first sample after reset, nonzero: no crossing
    step(0, 0, 0, 0, 0, 1, 100, 100);
    expect_set("R5 first", 7, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 50, 20);
    expect_set("R5 same sign", 7, 0, 0, 0);
    // R7 replace pending
    step(1, 1, 4, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, -5, 20);
    expect_set("R7 latest applied", 4, 1, 1, 1);
    chk("R2 eff muted", eff_atten_db, 80);
    // R6 sticky
    step(0, 0, 0, 0, 0, 1, -3, -2);
    chk("R6 sticky", zc_status, 1);
    step(1, 1, 0, 2, 0, 0, 0, 0);
    chk("R6 clear on load", zc_status, 0);
    // R5 zero-valued sample
    step(0, 0, 0, 0, 0, 1, -7, 0);
    expect_set("R5 zero sample", 0, 2, 0, 1);
    // R9 load coincides with crossing
    step(1, 1, 5, 0, 0, 1, 0, 5);
    expect_set("R9 load wins", 0, 2, 0, 0);
    step(0, 0, 0, 0, 0, 1, 3, 4);
    expect_set("R9 no crossing", 0, 2, 0, 0);
    step(0, 0, 0, 0, 0, 1, 3, 0);
    expect_set("R9 later crossing", 5, 0, 0, 1);
    // R8 hardware mute
    hw_mute = 1; #1;
    chk("R8 out_mute", out_mute, 1);
    chk("R8 eff", eff_atten_db, 80);
    chk("R8 applied mute", applied_mute, 0);
    chk("R8 atten kept", atten_db, 40);
    hw_mute = 0; #1;
    chk("R8 release", eff_atten_db, 40);
    // R3 ungated load discards pending
    step(1, 1, 6, 6, 1, 0, 0, 0);
    step(1, 0, 1, 1, 0, 0, 0, 0);
    expect_set("R3 immediate", 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, -1, -1);
    expect_set("R3 pending dropped", 1, 1, 0, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule